// File: doc/BRIEF.md
# Presettable Synchronous Cascadable Counter

This block is a small binary counter that changes state only on the rising clock edge. On each edge it can be cleared, loaded in parallel from a data input, advanced by one, or left as it is. Two enables control counting. The wide enable, `en_par`, gates only the count. The trickle enable, `en_trk`, gates both the count and the terminal-count output. Because of this, the terminal count of one stage can drive the trickle enable of the next stage. Stages chain into wider counters with no extra gating, and every stage shares the clock and the wide enable.

A build-time parameter chooses the clear style. In asynchronous mode a low `clear_n` zeroes the count at once, without waiting for the clock. In synchronous mode `clear_n` is sampled on the rising edge, and it then overrides load and both enables. The default width is 4 bits, so the count runs modulo 16.

Top module: `sync_preset_counter`

## Requirements
- R1: With ASYNC_CLEAR=1, a low `clear_n` drives `q` to 0 at once, without waiting for a clock edge, whatever the other inputs are.
- R2: With ASYNC_CLEAR=0, a low `clear_n` takes effect only on a rising edge. It leaves `q` unchanged until that edge and sets `q` to 0 on it, even when `load_n` is low or both enables are high.
- R3: With `clear_n` high, a low `load_n` copies `din` into `q` on the rising edge, whatever the values of `en_par` and `en_trk`.
- R4: With `clear_n` and `load_n` high, `q` increases by one on a rising edge when `en_par` and `en_trk` are both 1.
- R5: With `clear_n` and `load_n` high, `q` keeps its value across a rising edge when `en_par` or `en_trk` is 0.
- R6: The count is modulo 2^WIDTH: counting from the all-ones value (15 at the default width) gives 0.
- R7: `term` is 1 exactly when `en_trk` is 1 and `q` is all ones. It follows `en_trk` combinationally, without a clock edge, and does not depend on `en_par` or `load_n`.
- R8: Two 4-bit stages form an 8-bit counter when the upper stage's `en_trk` is driven from the lower stage's `term`, with the clock, clear, load and `en_par` shared. The pair counts 0x0F to 0x10 and 0xFF to 0x00.
- R9: After the asynchronous clear is released, the counter runs normally from 0, so the first counting edge gives 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter acts on its rising edge |
| clear_n | input | 1 | Active-low clear; asynchronous or synchronous according to ASYNC_CLEAR |
| load_n | input | 1 | Active-low parallel load |
| en_par | input | 1 | Wide count enable; gates counting only |
| en_trk | input | 1 | Trickle count enable; gates counting and `term` |
| din | input | WIDTH | Parallel load value |
| q | output | WIDTH | Current count |
| term | output | 1 | Terminal count: `en_trk` AND all bits of `q` |

## Verification
The bench builds three instances at the default 4-bit width. Two use ASYNC_CLEAR=1 and are chained so that one counter's `term` feeds the other's trickle enable. This makes the 8-bit carries at 0x0F and 0xFF, the mid-cycle asynchronous clear and the restart from zero reachable. The third instance uses ASYNC_CLEAR=0, so the bench can check sync-clear priority against load and enables and confirm that the clear has no effect before the edge. The bench also toggles `en_trk` with no clock edge in between to exercise the combinational terminal count.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_CLEAR = 2'd3
  } cnt_mode_e;
endpackage

// File: rtl/cnt_mode_sel.sv
module cnt_mode_sel
  import cnt_pkg::*;
(
  input  logic      clear_n,
  input  logic      load_n,
  input  logic      en_par,
  input  logic      en_trk,
  output cnt_mode_e mode
);
  // priority: clear, then load, then count, else hold
  always_comb begin
    if (!clear_n)                mode = MODE_CLEAR;
    else if (!load_n)            mode = MODE_LOAD;
    else if (en_par && en_trk)   mode = MODE_COUNT;
    else                         mode = MODE_HOLD;
  end
endmodule

// File: rtl/cnt_next_state.sv
module cnt_next_state
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  cnt_mode_e        mode,
  input  logic [WIDTH-1:0] q,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] d
);
  function automatic logic [WIDTH-1:0] f_step(input logic [WIDTH-1:0] v);
    return v + WIDTH'(1);
  endfunction

  always_comb begin
    unique case (mode)
      MODE_CLEAR: d = '0;
      MODE_LOAD:  d = din;
      MODE_COUNT: d = f_step(q);
      default:    d = q;
    endcase
  end
endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg #(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (ASYNC_CLEAR) begin : g_async
      always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) q <= '0;
        else          q <= d;
      end
    end else begin : g_sync
      // the clear is already folded into d by the mode selector
      always_ff @(posedge clk) begin
        q <= d;
      end
    end
  endgenerate
endmodule

// File: rtl/cnt_term_detect.sv
module cnt_term_detect #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_trk,
  output logic             term
);
  function automatic logic f_at_max(input logic [WIDTH-1:0] v);
    return &v;
  endfunction

  assign term = en_trk & f_at_max(q);
endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             load_n,
  input  logic             en_par,
  input  logic             en_trk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             term
);
  cnt_mode_e        mode;
  logic [WIDTH-1:0] d_next;

  cnt_mode_sel u_mode (
    .clear_n (clear_n),
    .load_n  (load_n),
    .en_par  (en_par),
    .en_trk  (en_trk),
    .mode    (mode)
  );

  cnt_next_state #(.WIDTH(WIDTH)) u_next (
    .mode (mode),
    .q    (q),
    .din  (din),
    .d    (d_next)
  );

  cnt_state_reg #(.WIDTH(WIDTH), .ASYNC_CLEAR(ASYNC_CLEAR)) u_reg (
    .clk     (clk),
    .clear_n (clear_n),
    .d       (d_next),
    .q       (q)
  );

  cnt_term_detect #(.WIDTH(WIDTH)) u_term (
    .q      (q),
    .en_trk (en_trk),
    .term   (term)
  );
endmodule

// File: rtl/sync_preset_counter_checks.sv
module sync_preset_counter_checks #(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input logic             clk,
  input logic             clear_n,
  input logic             load_n,
  input logic             en_par,
  input logic             en_trk,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             term
);
  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  generate
    if (ASYNC_CLEAR) begin : g_ac
      assert_async_clear_R1: assert property (@(posedge clk) disable iff (!started)
        !clear_n |-> (q == '0));
      assert_restart_R9: assert property (@(posedge clk) disable iff (!started)
        ($past(!clear_n) && clear_n && load_n && en_par && en_trk) |=>
          (!clear_n || q == WIDTH'(1)));
    end else begin : g_sc
      assert_sync_clear_R2: assert property (@(posedge clk) disable iff (!started)
        !clear_n |=> (q == '0));
    end
  endgenerate

  assert_load_R3: assert property (@(posedge clk) disable iff (!started)
    (clear_n && !load_n) |=> (!clear_n || q == $past(din)));

  assert_count_R4: assert property (@(posedge clk) disable iff (!started)
    (clear_n && load_n && en_par && en_trk) |=>
      (!clear_n || q == $past(q) + WIDTH'(1)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!started)
    (clear_n && load_n && !(en_par && en_trk)) |=> (!clear_n || $stable(q)));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!started)
    (clear_n && load_n && en_par && en_trk && (&q)) |=> (!clear_n || q == '0));

  always_comb begin
    if (started) begin
      assert_term_gate_R7: assert (!term || (en_trk && (&q)));
    end
  end
endmodule

bind sync_preset_counter sync_preset_counter_checks #(
  .WIDTH(WIDTH), .ASYNC_CLEAR(ASYNC_CLEAR)
) u_checks (
  .clk(clk), .clear_n(clear_n), .load_n(load_n), .en_par(en_par),
  .en_trk(en_trk), .din(din), .q(q), .term(term)
);

// File: tb/test_sync_preset_counter.sv
`timescale 1ns/1ps
module test_sync_preset_counter;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  // cascaded pair (asynchronous clear)
  logic       c_clear_n, c_load_n, c_ep, c_et;
  logic [7:0] c_din;
  logic [3:0] lo_q, hi_q;
  logic       lo_tc, hi_tc;
  // single stage (synchronous clear)
  logic       s_clear_n, s_load_n, s_ep, s_et;
  logic [3:0] s_din, s_q;
  logic       s_tc;

  int checks = 0;
  int fails  = 0;
  int cm = 0;
  int sm = 0;
  bit done = 1'b0;

  sync_preset_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b1)) i_sync_preset_counter (
    .clk(clk), .clear_n(c_clear_n), .load_n(c_load_n), .en_par(c_ep),
    .en_trk(c_et), .din(c_din[3:0]), .q(lo_q), .term(lo_tc));

  sync_preset_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b1)) i_sync_preset_counter_hi (
    .clk(clk), .clear_n(c_clear_n), .load_n(c_load_n), .en_par(c_ep),
    .en_trk(lo_tc), .din(c_din[7:4]), .q(hi_q), .term(hi_tc));

  sync_preset_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) i_sync_preset_counter_sc (
    .clk(clk), .clear_n(s_clear_n), .load_n(s_load_n), .en_par(s_ep),
    .en_trk(s_et), .din(s_din), .q(s_q), .term(s_tc));

  function automatic int exp_next(int cur, bit clr_n, bit ld_n, bit ep, bit et,
                                  int dv, int modulus);
    if (!clr_n)        return 0;
    if (!ld_n)         return dv % modulus;
    if (ep && et)      return (cur + 1) % modulus;
    return cur;
  endfunction

  function automatic bit exp_term(int cur, bit et, int lim);
    return et && (cur == lim);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // inputs are set at a falling edge; this advances over one rising edge
  task automatic step(input string tag);
    int ncm, nsm;
    ncm = exp_next(cm, c_clear_n, c_load_n, c_ep, c_et, int'(c_din), 256);
    nsm = exp_next(sm, s_clear_n, s_load_n, s_ep, s_et, int'(s_din), 16);
    @(negedge clk);
    cm = ncm;
    sm = nsm;
    chk({hi_q, lo_q} == 8'(cm), {tag, " cascade q"}, int'({hi_q, lo_q}), cm);
    chk(lo_tc == exp_term(cm % 16, c_et, 15), {tag, " R7 low term"}, int'(lo_tc),
        int'(exp_term(cm % 16, c_et, 15)));
    chk(hi_tc == exp_term(cm, c_et, 255), {tag, " R8 high term"}, int'(hi_tc),
        int'(exp_term(cm, c_et, 255)));
    chk(s_q == 4'(sm), {tag, " sync q"}, int'(s_q), sm);
    chk(s_tc == exp_term(sm, s_et, 15), {tag, " R7 sync term"}, int'(s_tc),
        int'(exp_term(sm, s_et, 15)));
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4242));
    c_clear_n = 1'b0; c_load_n = 1'b1; c_ep = 1'b0; c_et = 1'b0; c_din = 8'h00;
    s_clear_n = 1'b0; s_load_n = 1'b1; s_ep = 1'b0; s_et = 1'b0; s_din = 4'h0;
    @(negedge clk);
    step("R1 R2 reset");
    step("R1 R2 reset");

    // R3: load with enables low
    c_clear_n = 1'b1; s_clear_n = 1'b1;
    c_load_n = 1'b0; c_din = 8'h3A; s_load_n = 1'b0; s_din = 4'h9;
    step("R3 load");
    chk({hi_q, lo_q} == 8'h3A, "R3 load cascade", int'({hi_q, lo_q}), 8'h3A);
    chk(s_q == 4'h9, "R3 load sync", int'(s_q), 9);

    // R5: hold with one enable low each way
    c_load_n = 1'b1; s_load_n = 1'b1;
    c_ep = 1'b0; c_et = 1'b1; s_ep = 1'b0; s_et = 1'b1;
    step("R5 hold ep low");
    c_ep = 1'b1; c_et = 1'b0; s_ep = 1'b1; s_et = 1'b0;
    step("R5 hold et low");
    chk(s_q == 4'h9, "R5 hold sync", int'(s_q), 9);

    // R7: term follows en_trk without an edge, ignores en_par and load_n
    s_load_n = 1'b0; s_din = 4'hF; s_ep = 1'b0; s_et = 1'b0;
    step("R3 load 15");
    s_et = 1'b1; #1;
    chk(s_tc == 1'b1, "R7 term rises with en_trk", int'(s_tc), 1);
    s_et = 1'b0; #0.5;
    chk(s_tc == 1'b0, "R7 term falls with en_trk", int'(s_tc), 0);
    s_et = 1'b1; s_ep = 1'b0; s_load_n = 1'b0; #0.2;
    chk(s_tc == 1'b1, "R7 term ignores en_par and load_n", int'(s_tc), 1);

    // R4/R6: count 14 -> 15 -> 0
    s_din = 4'hE;
    step("R3 load 14");
    s_load_n = 1'b1; s_ep = 1'b1; s_et = 1'b1;
    step("R4 count");
    chk(s_q == 4'hF, "R4 count 14 to 15", int'(s_q), 15);
    step("R6 wrap");
    chk(s_q == 4'h0, "R6 wrap 15 to 0", int'(s_q), 0);

    // R8: cascade carries
    c_load_n = 1'b0; c_din = 8'h0F; c_ep = 1'b1; c_et = 1'b1;
    step("R8 load 0F");
    c_load_n = 1'b1;
    step("R8 carry");
    chk({hi_q, lo_q} == 8'h10, "R8 0F to 10", int'({hi_q, lo_q}), 8'h10);
    c_load_n = 1'b0; c_din = 8'hFE;
    step("R8 load FE");
    c_load_n = 1'b1;
    step("R8 FF");
    chk(hi_tc == 1'b1, "R8 high term at FF", int'(hi_tc), 1);
    step("R8 wrap");
    chk({hi_q, lo_q} == 8'h00, "R8 FF to 00", int'({hi_q, lo_q}), 0);

    // R2: sync clear waits for the edge and beats load and enables
    s_load_n = 1'b0; s_din = 4'h5;
    step("R3 load 5");
    s_clear_n = 1'b0; s_load_n = 1'b0; s_din = 4'h7; s_ep = 1'b1; s_et = 1'b1; #1;
    chk(s_q == 4'h5, "R2 no effect before edge", int'(s_q), 5);
    step("R2 sync clear");
    chk(s_q == 4'h0, "R2 clear priority", int'(s_q), 0);
    s_clear_n = 1'b1; s_load_n = 1'b1;

    // R1/R9: asynchronous clear mid-cycle, then restart from zero
    c_load_n = 1'b0; c_din = 8'h6C;
    step("R3 load 6C");
    c_load_n = 1'b1; c_clear_n = 1'b0; #1;
    chk({hi_q, lo_q} == 8'h00, "R1 immediate clear", int'({hi_q, lo_q}), 0);
    step("R1 held clear");
    c_clear_n = 1'b1; c_ep = 1'b1; c_et = 1'b1;
    step("R9 restart");
    chk({hi_q, lo_q} == 8'h01, "R9 first count after clear", int'({hi_q, lo_q}), 1);

    // random phase
    for (int i = 0; i < 400; i++) begin
      c_clear_n = ($urandom % 25) != 0;
      c_load_n  = ($urandom % 10) != 0;
      c_ep      = ($urandom % 5) != 0;
      c_et      = ($urandom % 5) != 0;
      c_din     = 8'($urandom);
      s_clear_n = ($urandom % 25) != 0;
      s_load_n  = ($urandom % 10) != 0;
      s_ep      = ($urandom % 5) != 0;
      s_et      = ($urandom % 5) != 0;
      s_din     = 4'($urandom);
      step("R1 R2 R3 R4 R5 R6 random");
    end
    finish_up();
  end
endmodule